// File: doc/BRIEF.md
# Receive Port Output Framer

This block sits between a demodulator and an external medium access controller. The demodulator hands it one bit at a time, each with a one-cycle valid strobe. It also supplies a start-of-frame detect pulse, a header-error flag and a level that marks the CRC16 field. The framer turns this into three signals for the controller: a serial data line, a bit clock for sampling it, and a ready signal that frames the transfer. Bits leave in the order they arrive. The demodulator delivers each field LSB first, so the line carries each field LSB first as well.

The ready signal opens a frame when a start-of-frame pulse arrives and closes it when receive-enable drops or a header error is flagged. The bit clock stays at its inactive level outside a frame and during the CRC16 field. Otherwise each accepted bit produces one clock pulse. The data line changes while the clock is inactive, so it is stable at the sampling edge. The block also turns a channel-busy indication into a registered clear-channel output. Both the bit clock and the clear-channel output have a configurable polarity.

Top module: `rx_port_framer`

## Requirements
- R1: When `sfd_det` is sampled high while `rx_ready` is low, `rx_en` is high and `hdr_err` is low, `rx_ready` is high from the next clock edge on.
- R2: When `rx_en` is sampled low or `hdr_err` is sampled high, `rx_ready` is low after that edge. This takes priority over a simultaneous `sfd_det`.
- R3: An `sfd_det` pulse while `rx_ready` is high has no effect. A new frame needs `rx_ready` to fall first and then a fresh `sfd_det` pulse.
- R4: A `bit_valid` strobe while `rx_ready` is low is ignored: `rx_data` stays 0 and `rx_bitclk` stays at its inactive level.
- R5: Accepted bits appear on `rx_data` in strobe order, so a field delivered LSB first leaves LSB first. Each bit is sampled once, at the inactive-to-active transition of `rx_bitclk`.
- R6: With the default high time of 2 cycles, a bit accepted at edge E is on `rx_data` after E. `rx_bitclk` stays inactive after E, is active after E+1 and E+2, and is inactive again after E+3.
- R7: A bit accepted while `crc_field` is high still updates `rx_data`, but `rx_bitclk` stays at its inactive level for that bit.
- R8: The inactive level of `rx_bitclk` is 0 when `cfg_clk_inv` is 0 and 1 when it is 1, and the active level is the opposite. The clock is held at the inactive level whenever it is suppressed.
- R9: `cca_out` after each edge equals the sampled `chan_busy` XOR the sampled `cfg_cca_inv`. With no inversion, 0 means clear and 1 means busy.
- R10: After reset `rx_ready`, `rx_data` and `cca_out` are 0, and `rx_bitclk` is at its inactive level.
- R11: `rx_data` never changes in a cycle where `rx_bitclk` is at its active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable; low puts the port in standby |
| sfd_det | input | 1 | One-cycle start-of-frame detect pulse |
| hdr_err | input | 1 | Header error flag, closes the frame |
| crc_field | input | 1 | High while CRC16 field bits are delivered |
| bit_valid | input | 1 | One-cycle strobe for `bit_data` |
| bit_data | input | 1 | Demodulated bit |
| cfg_clk_inv | input | 1 | Inverts the bit clock polarity |
| cfg_cca_inv | input | 1 | Inverts the clear-channel output |
| chan_busy | input | 1 | Channel busy indication from assessment logic |
| rx_ready | output | 1 | Frame/ready signal toward the controller |
| rx_data | output | 1 | Serial received data |
| rx_bitclk | output | 1 | Bit clock for `rx_data` |
| cca_out | output | 1 | Clear-channel output |

## Verification
A table of frames sends bytes with alternating, all-ones, single-bit and mixed patterns, under both clock polarities. Some bytes have their upper bits marked as CRC16 field. A bench monitor rebuilds each byte from the clock's active transitions. A reversed bit order, a wrong polarity or a pulse leaking through the CRC field therefore shows up as a wrong byte or a wrong bit count. Directed tests check the exact cycle of each clock phase of a single bit. They also cover strobes outside a frame, a repeated start pulse inside a frame, a start pulse that coincides with a header error, and every combination of busy and inversion on the clear-channel path.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic {
        FR_IDLE   = 1'b0,
        FR_ACTIVE = 1'b1
    } frame_state_e;

    typedef struct packed {
        logic valid;
        logic data;
        logic crc;
    } demod_bit_t;

    localparam int DEFAULT_HI_CYCLES = 2;

    function automatic logic apply_pol(input logic raw, input logic inv);
        return raw ^ inv;
    endfunction

    function automatic int cnt_width(input int hi_cycles);
        return $clog2(hi_cycles + 2);
    endfunction

endpackage

// File: rtl/rxf_frame_ctl.sv
module rxf_frame_ctl
    import rxf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rx_en,
    input  logic sfd_det,
    input  logic hdr_err,
    output logic frame_on,
    output logic frame_drop
);

    frame_state_e state_q, state_d;

    // Disable and header error close the frame ahead of any start pulse.
    assign frame_drop = !rx_en || hdr_err;

    always_comb begin
        state_d = state_q;
        if (frame_drop) begin
            state_d = FR_IDLE;
        end else if (state_q == FR_IDLE && sfd_det) begin
            state_d = FR_ACTIVE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign frame_on = (state_q == FR_ACTIVE);

endmodule

// File: rtl/rxf_bitclk_gen.sv
module rxf_bitclk_gen
    import rxf_pkg::*;
#(
    parameter int HI_CYCLES = DEFAULT_HI_CYCLES
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_on,
    input  logic       frame_drop,
    input  demod_bit_t bit_in,
    output logic       ser_q,
    output logic       raw_clk
);

    localparam int CNT_W = cnt_width(HI_CYCLES);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(HI_CYCLES + 1);
    localparam logic [CNT_W-1:0] HI_VAL   = CNT_W'(HI_CYCLES);

    logic [CNT_W-1:0] cnt_q;
    logic             crc_q;
    logic             accept;

    assign accept = bit_in.valid && frame_on && !frame_drop;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            crc_q <= 1'b0;
            ser_q <= 1'b0;
        end else if (frame_drop) begin
            cnt_q <= '0;
            crc_q <= 1'b0;
            ser_q <= 1'b0;
        end else if (accept) begin
            // Data moves during the setup phase, the pulse follows.
            cnt_q <= LOAD_VAL;
            crc_q <= bit_in.crc;
            ser_q <= bit_in.data;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign raw_clk = (cnt_q != '0) && (cnt_q <= HI_VAL) && !crc_q && frame_on;

endmodule

// File: rtl/rxf_cca_drive.sv
module rxf_cca_drive
    import rxf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic chan_busy,
    input  logic cfg_cca_inv,
    output logic cca_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cca_out <= 1'b0;
        end else begin
            cca_out <= apply_pol(chan_busy, cfg_cca_inv);
        end
    end

endmodule

// File: rtl/rx_port_framer.sv
module rx_port_framer
    import rxf_pkg::*;
#(
    parameter int HI_CYCLES = DEFAULT_HI_CYCLES
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_en,
    input  logic sfd_det,
    input  logic hdr_err,
    input  logic crc_field,
    input  logic bit_valid,
    input  logic bit_data,
    input  logic cfg_clk_inv,
    input  logic cfg_cca_inv,
    input  logic chan_busy,
    output logic rx_ready,
    output logic rx_data,
    output logic rx_bitclk,
    output logic cca_out
);

    logic       frame_on;
    logic       frame_drop;
    logic       raw_clk;
    demod_bit_t bit_in;

    assign bit_in = '{valid: bit_valid, data: bit_data, crc: crc_field};

    rxf_frame_ctl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .rx_en      (rx_en),
        .sfd_det    (sfd_det),
        .hdr_err    (hdr_err),
        .frame_on   (frame_on),
        .frame_drop (frame_drop)
    );

    rxf_bitclk_gen #(.HI_CYCLES(HI_CYCLES)) u_clk (
        .clk        (clk),
        .rst        (rst),
        .frame_on   (frame_on),
        .frame_drop (frame_drop),
        .bit_in     (bit_in),
        .ser_q      (rx_data),
        .raw_clk    (raw_clk)
    );

    rxf_cca_drive u_cca (
        .clk         (clk),
        .rst         (rst),
        .chan_busy   (chan_busy),
        .cfg_cca_inv (cfg_cca_inv),
        .cca_out     (cca_out)
    );

    assign rx_ready  = frame_on;
    assign rx_bitclk = apply_pol(raw_clk, cfg_clk_inv);

endmodule

// File: rtl/rx_port_framer_chk.sv
module rx_port_framer_chk (
    input logic clk,
    input logic rst,
    input logic rx_en,
    input logic sfd_det,
    input logic hdr_err,
    input logic crc_field,
    input logic bit_valid,
    input logic cfg_clk_inv,
    input logic cfg_cca_inv,
    input logic chan_busy,
    input logic rx_ready,
    input logic rx_data,
    input logic rx_bitclk,
    input logic cca_out
);

    assert_ready_rise_R1: assert property (@(posedge clk) disable iff (rst)
        (rx_en && !hdr_err && sfd_det && !rx_ready) |=> rx_ready);

    assert_ready_fall_R2: assert property (@(posedge clk) disable iff (rst)
        (!rx_en || hdr_err) |=> !rx_ready);

    assert_ready_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (rx_ready && rx_en && !hdr_err) |=> rx_ready);

    assert_no_clk_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !rx_ready |-> (rx_bitclk == cfg_clk_inv));

    assert_setup_phase_R6: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && rx_ready && rx_en && !hdr_err) |=> (rx_bitclk == cfg_clk_inv));

    assert_cca_map_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cca_out == ($past(chan_busy) ^ $past(cfg_cca_inv))));

    assert_data_stable_R11: assert property (@(posedge clk) disable iff (rst)
        (rx_bitclk != cfg_clk_inv) |-> $stable(rx_data));

endmodule

bind rx_port_framer rx_port_framer_chk chk_i (.*);

// File: tb/rx_port_framer_tb_top.sv
module rx_port_framer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HI = 2;
    localparam int N_VEC = 6;
    // {data[7:0], crc_mask[7:0], clk_inv}
    localparam logic [16:0] VECS [N_VEC] = '{
        {8'hA5, 8'h00, 1'b0},
        {8'h3C, 8'h00, 1'b1},
        {8'hFF, 8'h00, 1'b0},
        {8'h01, 8'h00, 1'b0},
        {8'hD2, 8'hF0, 1'b0},
        {8'h96, 8'hC0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_en = 1'b0, sfd_det = 1'b0, hdr_err = 1'b0, crc_field = 1'b0;
    logic bit_valid = 1'b0, bit_data = 1'b0;
    logic cfg_clk_inv = 1'b0, cfg_cca_inv = 1'b0, chan_busy = 1'b0;
    logic rx_ready, rx_data, rx_bitclk, cca_out;

    int n_chk = 0;
    int n_bad = 0;

    logic       prev_clk = 1'b0;
    logic [7:0] cap_bits = '0;
    int         cap_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_port_framer #(.HI_CYCLES(HI)) dut_i (
        .clk(clk), .rst(rst), .rx_en(rx_en), .sfd_det(sfd_det),
        .hdr_err(hdr_err), .crc_field(crc_field), .bit_valid(bit_valid),
        .bit_data(bit_data), .cfg_clk_inv(cfg_clk_inv),
        .cfg_cca_inv(cfg_cca_inv), .chan_busy(chan_busy),
        .rx_ready(rx_ready), .rx_data(rx_data), .rx_bitclk(rx_bitclk),
        .cca_out(cca_out)
    );

    // Monitor: capture rx_data at inactive-to-active clock transitions.
    always @(negedge clk) begin
        if (!rst && rx_bitclk != cfg_clk_inv && prev_clk == cfg_clk_inv) begin
            if (cap_cnt < 8) cap_bits[cap_cnt] = rx_data;
            cap_cnt = cap_cnt + 1;
        end
        prev_clk = rx_bitclk;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_sfd();
        @(negedge clk) sfd_det = 1'b1;
        @(negedge clk) sfd_det = 1'b0;
    endtask

    task automatic pulse_err();
        @(negedge clk) hdr_err = 1'b1;
        @(negedge clk) hdr_err = 1'b0;
    endtask

    task automatic send_bit(input logic d, input logic crc);
        @(negedge clk) begin bit_valid = 1'b1; bit_data = d; crc_field = crc; end
        @(negedge clk) begin bit_valid = 1'b0; crc_field = 1'b0; end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 ready", rx_ready, 0);
        check("R10 data", rx_data, 0);
        check("R10 bitclk", rx_bitclk, 0);
        check("R10 cca", cca_out, 0);
        @(negedge clk) begin rst = 1'b0; rx_en = 1'b1; end

        // Frame table: R5, R7, R8
        for (int v = 0; v < N_VEC; v++) begin
            logic [7:0] dat, msk, exp_bits;
            int exp_cnt;
            dat = VECS[v][16:9];
            msk = VECS[v][8:1];
            exp_bits = '0;
            exp_cnt = 0;
            for (int b = 0; b < 8; b++) begin
                if (!msk[b]) begin
                    exp_bits[exp_cnt] = dat[b];
                    exp_cnt++;
                end
            end
            @(negedge clk) cfg_clk_inv = VECS[v][0];
            @(negedge clk);
            check("R8 idle level", rx_bitclk, VECS[v][0]);
            cap_bits = '0;
            cap_cnt = 0;
            pulse_sfd();
            for (int b = 0; b < 8; b++) send_bit(dat[b], msk[b]);
            check("R5 bits", cap_bits, exp_bits);
            check("R7 pulse count", cap_cnt, exp_cnt);
            pulse_err();
            check("R2 hdr_err drop", rx_ready, 0);
        end
        @(negedge clk) cfg_clk_inv = 1'b0;

        // R1 and exact phase timing R6
        pulse_sfd();
        check("R1 ready rise", rx_ready, 1);
        @(negedge clk) begin bit_valid = 1'b1; bit_data = 1'b1; end
        @(negedge clk) bit_valid = 1'b0;
        check("R6 data after E", rx_data, 1);
        check("R6 setup inactive", rx_bitclk, 0);
        @(negedge clk) check("R6 active E+1", rx_bitclk, 1);
        @(negedge clk) check("R6 active E+2", rx_bitclk, 1);
        @(negedge clk) check("R6 inactive E+3", rx_bitclk, 0);

        // R7: CRC field bit updates data but no pulse
        @(negedge clk) begin bit_valid = 1'b1; bit_data = 1'b0; crc_field = 1'b1; end
        @(negedge clk) begin bit_valid = 1'b0; crc_field = 1'b0; end
        check("R7 crc data", rx_data, 0);
        for (int k = 0; k < 4; k++) begin
            check("R7 crc clk held", rx_bitclk, 0);
            @(negedge clk);
        end

        // R3: repeated start pulse inside a frame is ignored
        pulse_sfd();
        check("R3 still ready", rx_ready, 1);
        @(negedge clk) rx_en = 1'b0;
        @(negedge clk) check("R2 disable drop", rx_ready, 0);
        @(negedge clk) rx_en = 1'b1;
        pulse_sfd();
        check("R3 fresh frame", rx_ready, 1);

        // R2 priority over simultaneous start pulse
        @(negedge clk) hdr_err = 1'b1;
        @(negedge clk) begin hdr_err = 1'b1; sfd_det = 1'b1; end
        @(negedge clk) begin hdr_err = 1'b0; sfd_det = 1'b0; end
        check("R2 priority", rx_ready, 0);

        // R4: strobe outside a frame
        @(negedge clk) begin bit_valid = 1'b1; bit_data = 1'b1; end
        @(negedge clk) bit_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            check("R4 data", rx_data, 0);
            check("R4 clk", rx_bitclk, 0);
            @(negedge clk);
        end

        // R9 clear-channel polarity
        for (int c = 0; c < 4; c++) begin
            @(negedge clk) begin chan_busy = c[0]; cfg_cca_inv = c[1]; end
            @(negedge clk) check("R9 cca", cca_out, c[0] ^ c[1]);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule